// File: doc/BRIEF.md
# Multichannel PWM Generator with Pulse Spreading

This block drives a parameterised number of independent PWM outputs from one register write port. Each channel has its own control word (enable, output polarity, count-clock source, spreading mode, period), its own duty value and its own 12-bit start delay. A channel counts ticks taken from the core clock, from a peripheral tick strobe, or from an external clock pin that is synchronised and edge-detected inside the block.

A channel can emit one contiguous pulse per period, or share its high time over 4 or 32 equal slots of the period. The slot form keeps the average level while raising the ripple frequency. A group-restart register restarts any chosen set of channels on the same clock edge. Each restarted channel reloads its start delay and clears its counters, so programming staggered delays before a group restart gives multiphase outputs with known phase offsets.

Two resets are provided. The PWM reset clears all channel state and the outputs. The system reset clears only the write capture stage and the external-clock synchroniser, so a running waveform continues through a system reset.

Top module: `spread_pwm_top`

## Requirements
- R1: While `pwm_rst_n` is low, every output is 0 and all channel registers clear. After the reset is released, every channel is disabled with polarity 0, so all outputs stay 0.
- R2: Pulsing `sys_rst_n` low changes neither the channel settings nor the outputs. A running channel keeps the same high count per period.
- R3: A write reaches address {channel, select}, where select 0 is the control word, 1 is the duty, 2 is the start delay and 3 is the group-restart mask (channel field ignored). The control word holds enable in bit 0, polarity in bit 1, clock source in bits 3:2, spreading mode in bits 5:4 and the period field in bits 15:8. A write to one channel leaves every other channel unchanged. A write takes effect one clock after it is captured.
- R4: A disabled channel drives its inactive level. The inactive level is 0 with polarity 0 and 1 with polarity 1, and a polarity of 1 inverts the active level.
- R5: In contiguous mode (spreading field 0 or 3), a period lasts period field + 1 ticks, and the output is active for the first `duty` ticks. A duty of 0 keeps the output inactive, and a duty equal to or above the period keeps it active for the whole period.
- R6: With spreading field 1 (4 slots) or 2 (32 slots), the period is split into N equal slots. Each slot is active for floor(duty/N) ticks at its start, and the first duty mod N slots get one extra tick. Duty at or above the period gives a fully active period.
- R7: Clock-source field 0 or 3 counts every core clock, 1 counts cycles with `per_tick_i` high, and 2 counts rising edges of `ext_clk_i` after a two-stage synchroniser. Without a tick, the channel's counters and output hold.
- R8: After a restart, the channel stays inactive for `delay` ticks and then begins its first period. With a delay of 0, the first period starts at once.
- R9: Writing a mask to the group-restart register restarts every selected channel on the same edge. Channels with equal settings then produce identical outputs, and channels whose delays differ by d produce the same waveform shifted by d ticks.
- R10: A new duty, period or spreading mode takes effect only at the start of the next period or on a restart. The current period finishes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwm_rst_n | input | 1 | Asynchronous active-low reset for channel state and outputs |
| sys_rst_n | input | 1 | Asynchronous active-low system reset for the write stage and synchroniser |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (4) | Write address {channel, select} |
| wr_data_i | input | 16 | Write data |
| per_tick_i | input | 1 | Peripheral count enable, one cycle per tick |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| pwm_o | output | NCH (4) | PWM outputs, one per channel |

## Verification
On every cycle, the assertions check the following. Counters and the delay hold when no tick arrives. Slot and offset counters stay inside the current slot geometry. A restart clears the phase counters. The working duty changes only at a period boundary. A channel in its delay drives its inactive level. The synchronised external edge lasts one cycle. The bench scenarios alone can show the following: the high-time counts and pulse counts per period for each spreading mode, the shift between channels with staggered delays, the persistence through a system reset, and the old duty governing the remainder of a period after a new value is written.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    SRC_CORE     = 2'd0,
    SRC_PERI     = 2'd1,
    SRC_EXT      = 2'd2,
    SRC_CORE_ALT = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    SPR_NONE     = 2'd0,
    SPR_FOUR     = 2'd1,
    SPR_THIRTY2  = 2'd2,
    SPR_NONE_ALT = 2'd3
  } spr_e;

  typedef struct packed {
    logic en;
    logic pol;
    src_e src;
    spr_e spr;
  } ch_ctl_t;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_DUTY = 2'd1;
  localparam logic [1:0] SEL_DLY  = 2'd2;
  localparam logic [1:0] SEL_SYNC = 2'd3;

  // log2 of the slot count for a spreading mode
  function automatic logic [2:0] spr_shift(spr_e m);
    case (m)
      SPR_FOUR:    return 3'd2;
      SPR_THIRTY2: return 3'd5;
      default:     return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/spwm_rst_sync.sv
module spwm_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stage_q <= 2'b00;
    else          stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/spwm_tick_gen.sv
module spwm_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic ext_tick_o
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb sh_d = {sh_q[1:0], ext_clk_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  // rising edge after two synchroniser stages
  assign ext_tick_o = sh_q[1] & ~sh_q[2];

  p_ext_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_tick_o |=> !ext_tick_o);
endmodule

// File: rtl/spwm_regs.sv
module spwm_regs #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned DLY_W  = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    sys_rst_ni,
  input  logic                    pwm_rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output spwm_pkg::ch_ctl_t       ctl_o   [NCH],
  output logic [PER_W-1:0]        per_o   [NCH],
  output logic [DATA_W-1:0]       duty_o  [NCH],
  output logic [DLY_W-1:0]        dly_o   [NCH],
  output logic [NCH-1:0]          restart_o
);
  import spwm_pkg::*;

  localparam int unsigned CH_W = ADDR_W - 2;

  // write capture stage, system reset domain
  logic              wv_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni) begin
      wv_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wv_q <= wr_en_i;
      wa_q <= wr_addr_i;
      wd_q <= wr_data_i;
    end
  end

  logic [CH_W-1:0] ch_sel;
  logic [1:0]      fld_sel;
  logic            spare_unused;

  assign ch_sel       = wa_q[ADDR_W-1:2];
  assign fld_sel      = wa_q[1:0];
  assign spare_unused = ^wd_q[7:6];
  assign restart_o    = (wv_q && fld_sel == SEL_SYNC) ? wd_q[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_chreg
    logic        hit;
    ch_ctl_t     ctl_q, ctl_d;
    logic [PER_W-1:0]  per_q, per_d;
    logic [DATA_W-1:0] duty_q, duty_d;
    logic [DLY_W-1:0]  dly_q, dly_d;

    assign hit = wv_q && (ch_sel == CH_W'(g));

    always_comb begin
      ctl_d  = ctl_q;
      per_d  = per_q;
      duty_d = duty_q;
      dly_d  = dly_q;
      if (hit && fld_sel == SEL_CTL) begin
        ctl_d.en  = wd_q[0];
        ctl_d.pol = wd_q[1];
        ctl_d.src = src_e'(wd_q[3:2]);
        ctl_d.spr = spr_e'(wd_q[5:4]);
        per_d     = wd_q[8 +: PER_W];
      end
      if (hit && fld_sel == SEL_DUTY) duty_d = wd_q;
      if (hit && fld_sel == SEL_DLY)  dly_d  = wd_q[DLY_W-1:0];
    end

    always_ff @(posedge clk_i or negedge pwm_rst_ni) begin
      if (!pwm_rst_ni) begin
        ctl_q  <= '0;
        per_q  <= '0;
        duty_q <= '0;
        dly_q  <= '0;
      end else begin
        ctl_q  <= ctl_d;
        per_q  <= per_d;
        duty_q <= duty_d;
        dly_q  <= dly_d;
      end
    end

    assign ctl_o[g]  = ctl_q;
    assign per_o[g]  = per_q;
    assign duty_o[g] = duty_q;
    assign dly_o[g]  = dly_q;
  end

  // R9: a restart mask only appears one cycle after a bus write
  p_sync_from_bus_r9: assert property (@(posedge clk_i)
    disable iff (!pwm_rst_ni || !sys_rst_ni)
    (restart_o != '0) |-> $past(wr_en_i));
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
  parameter int unsigned PER_W  = 8,
  parameter int unsigned DLY_W  = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                restart_i,
  input  spwm_pkg::ch_ctl_t   ctl_i,
  input  logic [PER_W-1:0]    per_i,
  input  logic [DATA_W-1:0]   duty_i,
  input  logic [DLY_W-1:0]    dly_i,
  output logic                pwm_o
);
  import spwm_pkg::*;

  localparam int unsigned LEN_W = PER_W + 1;

  logic [PER_W-1:0]  off_q, off_d;
  logic [4:0]        slot_q, slot_d;
  logic              run_q, run_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [DATA_W-1:0] wduty_q, wduty_d;
  logic [LEN_W-1:0]  wlen_q, wlen_d;
  logic [2:0]        wsh_q, wsh_d;
  logic              wfull_q, wfull_d;
  logic              out_q, out_d;

  // working set derived from the programmed registers
  logic [LEN_W-1:0]  per_len, len_raw, new_len;
  logic [2:0]        new_sh;
  logic              new_full;

  assign per_len  = {1'b0, per_i} + LEN_W'(1);
  assign new_sh   = spr_shift(ctl_i.spr);
  assign len_raw  = per_len >> new_sh;
  assign new_len  = (len_raw == '0) ? LEN_W'(1) : len_raw;
  assign new_full = duty_i >= DATA_W'(per_len);

  // slot geometry of the running period
  logic [4:0]        slot_mask, rem;
  logic [DATA_W-1:0] base, hi_len;
  logic              extra, active, end_slot, end_per, load;

  assign slot_mask = 5'((6'd1 << wsh_q) - 6'd1);
  assign base      = wduty_q >> wsh_q;
  assign rem       = wduty_q[4:0] & slot_mask;
  assign extra     = slot_q < rem;
  assign hi_len    = base + DATA_W'(extra);
  assign active    = run_q && (wfull_q || (DATA_W'(off_q) < hi_len));
  assign end_slot  = ({1'b0, off_q} == wlen_q - LEN_W'(1));
  assign end_per   = end_slot && (slot_q == slot_mask);
  assign load      = restart_i || !ctl_i.en;

  always_comb begin
    off_d   = off_q;
    slot_d  = slot_q;
    run_d   = run_q;
    dly_d   = dly_q;
    wduty_d = wduty_q;
    wlen_d  = wlen_q;
    wsh_d   = wsh_q;
    wfull_d = wfull_q;
    if (load) begin
      off_d   = '0;
      slot_d  = '0;
      dly_d   = dly_i;
      run_d   = (dly_i == '0);
      wduty_d = duty_i;
      wlen_d  = new_len;
      wsh_d   = new_sh;
      wfull_d = new_full;
    end else if (tick_i) begin
      if (!run_q) begin
        dly_d = dly_q - DLY_W'(1);
        if (dly_q == DLY_W'(1)) run_d = 1'b1;
      end else if (end_slot) begin
        off_d = '0;
        if (end_per) begin
          slot_d  = '0;
          wduty_d = duty_i;
          wlen_d  = new_len;
          wsh_d   = new_sh;
          wfull_d = new_full;
        end else begin
          slot_d = slot_q + 5'd1;
        end
      end else begin
        off_d = off_q + PER_W'(1);
      end
    end
    out_d = ctl_i.en ? (active ^ ctl_i.pol) : ctl_i.pol;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      slot_q  <= '0;
      run_q   <= 1'b0;
      dly_q   <= '0;
      wduty_q <= '0;
      wlen_q  <= LEN_W'(1);
      wsh_q   <= '0;
      wfull_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      off_q   <= off_d;
      slot_q  <= slot_d;
      run_q   <= run_d;
      dly_q   <= dly_d;
      wduty_q <= wduty_d;
      wlen_q  <= wlen_d;
      wsh_q   <= wsh_d;
      wfull_q <= wfull_d;
      out_q   <= out_d;
    end
  end

  assign pwm_o = out_q;

  p_hold_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.en && !restart_i && !tick_i) |=>
      ($stable(off_q) && $stable(slot_q) && $stable(dly_q) && $stable(run_q)));

  p_slot_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((slot_q <= slot_mask) && ({1'b0, off_q} < wlen_q)));

  p_restart_phase_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (off_q == '0 && slot_q == '0));

  p_latch_boundary_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wduty_q) |-> (off_q == '0 && slot_q == '0));

  p_delay_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.en && !run_q) |=> (pwm_o == $past(ctl_i.pol)));
endmodule

// File: rtl/spread_pwm_top.sv
module spread_pwm_top #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned DLY_W  = 12,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = $clog2(NCH) + 2
) (
  input  logic              clk,
  input  logic              pwm_rst_n,
  input  logic              sys_rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              per_tick_i,
  input  logic              ext_clk_i,
  output logic [NCH-1:0]    pwm_o
);
  import spwm_pkg::*;

  logic pwm_rst_s, sys_rst_s, ext_tick;

  spwm_rst_sync u_pwm_rst (.clk_i(clk), .arst_ni(pwm_rst_n), .rst_no(pwm_rst_s));
  spwm_rst_sync u_sys_rst (.clk_i(clk), .arst_ni(sys_rst_n), .rst_no(sys_rst_s));

  spwm_tick_gen u_tick (
    .clk_i(clk), .rst_ni(sys_rst_s), .ext_clk_i(ext_clk_i), .ext_tick_o(ext_tick)
  );

  ch_ctl_t           ctl  [NCH];
  logic [PER_W-1:0]  per  [NCH];
  logic [DATA_W-1:0] duty [NCH];
  logic [DLY_W-1:0]  dly  [NCH];
  logic [NCH-1:0]    restart;

  spwm_regs #(
    .NCH(NCH), .PER_W(PER_W), .DLY_W(DLY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i(clk), .sys_rst_ni(sys_rst_s), .pwm_rst_ni(pwm_rst_s),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ctl_o(ctl), .per_o(per), .duty_o(duty), .dly_o(dly), .restart_o(restart)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic tick;
    always_comb begin
      case (ctl[g].src)
        SRC_PERI: tick = per_tick_i;
        SRC_EXT:  tick = ext_tick;
        default:  tick = 1'b1;
      endcase
    end

    spwm_channel #(.PER_W(PER_W), .DLY_W(DLY_W), .DATA_W(DATA_W)) u_ch (
      .clk_i(clk), .rst_ni(pwm_rst_s), .tick_i(tick), .restart_i(restart[g]),
      .ctl_i(ctl[g]), .per_i(per[g]), .duty_i(duty[g]), .dly_i(dly[g]),
      .pwm_o(pwm_o[g])
    );
  end

  p_rst_quiet_r1: assert property (@(posedge clk)
    !pwm_rst_n |-> (pwm_o == '0));
endmodule

// File: tb/spread_pwm_top_tb_top.sv
module spread_pwm_top_tb_top;

  logic       clk = 1'b0;
  logic       pwm_rst_n, sys_rst_n, wr_en, per_tick, ext_clk;
  logic [3:0] wr_addr;
  logic [15:0] wr_data;
  logic [3:0] pwm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  spread_pwm_top dut_i (
    .clk(clk), .pwm_rst_n(pwm_rst_n), .sys_rst_n(sys_rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .per_tick_i(per_tick), .ext_clk_i(ext_clk), .pwm_o(pwm)
  );

  typedef struct packed {
    logic [1:0]  spr;
    logic        pol;
    logic [7:0]  per;
    logic [15:0] duty;
    logic [15:0] hi;
    logic [7:0]  rises;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd15, 16'd5,  16'd5,  8'd1,  4'd5},
    '{2'd0, 1'b0, 8'd15, 16'd0,  16'd0,  8'd0,  4'd5},
    '{2'd0, 1'b0, 8'd15, 16'd16, 16'd16, 8'd0,  4'd5},
    '{2'd0, 1'b0, 8'd15, 16'd40, 16'd16, 8'd0,  4'd5},
    '{2'd1, 1'b0, 8'd15, 16'd6,  16'd6,  8'd4,  4'd6},
    '{2'd1, 1'b0, 8'd15, 16'd3,  16'd3,  8'd3,  4'd6},
    '{2'd2, 1'b0, 8'd63, 16'd40, 16'd40, 8'd24, 4'd6},
    '{2'd2, 1'b0, 8'd63, 16'd64, 16'd64, 8'd0,  4'd6},
    '{2'd1, 1'b0, 8'd7,  16'd1,  16'd1,  8'd1,  4'd6},
    '{2'd2, 1'b0, 8'd63, 16'd33, 16'd33, 8'd31, 4'd6},
    '{2'd0, 1'b1, 8'd15, 16'd5,  16'd11, 8'd1,  4'd4},
    '{2'd0, 1'b1, 8'd15, 16'd0,  16'd16, 8'd0,  4'd4}
  };

  function automatic string rq(input logic [3:0] n);
    case (n)
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {2'(ch), 2'(sel)}; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctlw(input bit en, input bit pol, input int src,
                                       input int spr, input int per);
    return {8'(per), 2'b00, 2'(spr), 2'(src), pol, en};
  endfunction

  task automatic measure(input int ch, input int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk);
    prev = pwm[ch];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[ch]) hi++;
      if (pwm[ch] && !prev) rises++;
      prev = pwm[ch];
    end
  endtask

  task automatic ext_edge();
    ext_clk = 1'b1; repeat (6) @(posedge clk);
    ext_clk = 1'b0; repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic per_pulse();
    @(negedge clk) per_tick = 1'b1;
    @(negedge clk) per_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, rs, t;
    logic s0 [41];
    logic s1 [41];
    logic s2 [41];
    pwm_rst_n = 1'b0; sys_rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    per_tick = 1'b0; ext_clk = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset", int'(pwm), 0);
    pwm_rst_n = 1'b1; sys_rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs after reset", int'(pwm), 0);

    // R4: disabled channel drives its inactive level, duty ignored
    wr(3, 1, 16'd5);
    wr(3, 0, ctlw(0, 1, 0, 0, 15));
    measure(3, 40, hi, rs);
    chk("R4 disabled pol=1 level", hi, 40);
    wr(3, 0, ctlw(0, 0, 0, 0, 15));
    measure(3, 40, hi, rs);
    chk("R4 disabled pol=0 level", hi, 0);

    // table walk on channel 0, core clock
    for (int v = 0; v < NV; v++) begin
      t = int'(VECS[v].per) + 1;
      wr(0, 1, VECS[v].duty);
      wr(0, 2, 16'd0);
      wr(0, 0, ctlw(1, VECS[v].pol, 0, int'(VECS[v].spr), int'(VECS[v].per)));
      wr(0, 3, 16'h0001);
      repeat (t + 6) @(posedge clk);
      measure(0, 2 * t, hi, rs);
      chk({rq(VECS[v].req), " high ticks"}, hi, 2 * int'(VECS[v].hi));
      chk({rq(VECS[v].req), " pulses"}, rs, 2 * int'(VECS[v].rises));
    end

    // R3: writes to other channels leave channel 0 alone
    wr(0, 1, 16'd5);
    wr(0, 0, ctlw(1, 0, 0, 0, 15));
    wr(0, 3, 16'h0001);
    wr(1, 1, 16'd12);
    wr(1, 0, ctlw(1, 1, 0, 1, 31));
    wr(2, 2, 16'd7);
    repeat (20) @(posedge clk);
    measure(0, 32, hi, rs);
    chk("R3 channel 0 high ticks kept", hi, 10);
    chk("R3 channel 0 pulses kept", rs, 2);

    // R2: system reset during run
    t = 0; hi = 0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (i == 8)  sys_rst_n = 1'b0;
      if (i == 12) sys_rst_n = 1'b1;
      if (pwm[0]) hi++;
    end
    chk("R2 high ticks across system reset", hi, 10);
    repeat (8) @(posedge clk);
    measure(0, 32, hi, rs);
    chk("R2 settings kept after system reset", hi, 10);

    // R8 / R9: staggered delay and group restart
    wr(0, 0, ctlw(1, 0, 0, 0, 15)); wr(0, 1, 16'd5); wr(0, 2, 16'd0);
    wr(1, 0, ctlw(1, 0, 0, 0, 15)); wr(1, 1, 16'd5); wr(1, 2, 16'd3);
    wr(2, 0, ctlw(1, 0, 0, 0, 15)); wr(2, 1, 16'd5); wr(2, 2, 16'd0);
    repeat (20) @(posedge clk);
    wr(0, 3, 16'h0007);
    @(posedge clk);
    @(posedge clk);
    for (int k = 0; k < 41; k++) begin
      @(negedge clk);
      s0[k] = pwm[0]; s1[k] = pwm[1]; s2[k] = pwm[2];
    end
    chk("R8 zero delay starts active", int'(s0[0]), 1);
    chk("R8 delayed channel quiet tick0", int'(s1[0]), 0);
    chk("R8 delayed channel quiet tick2", int'(s1[2]), 0);
    chk("R8 delayed channel starts after 3", int'(s1[3]), 1);
    hi = 0; rs = 0;
    for (int k = 3; k < 41; k++) if (s1[k] != s0[k-3]) hi++;
    for (int k = 0; k < 41; k++) if (s2[k] != s0[k]) rs++;
    chk("R9 shift of 3 ticks between channels", hi, 0);
    chk("R9 equal channels in phase", rs, 0);

    // R7: external clock source on channel 1, period 4, duty 2
    wr(1, 0, ctlw(1, 0, 2, 0, 3)); wr(1, 1, 16'd2); wr(1, 2, 16'd0);
    wr(0, 3, 16'h0002);
    repeat (6) @(negedge clk);
    chk("R7 ext start level", int'(pwm[1]), 1);
    repeat (10) @(negedge clk);
    chk("R7 holds without ext edge", int'(pwm[1]), 1);
    for (int k = 1; k <= 8; k++) begin
      ext_edge();
      chk("R7 ext tick pattern", int'(pwm[1]), int'((k % 4) < 2));
    end

    // R10: duty written mid-period applies at next period
    wr(0, 3, 16'h0002);
    repeat (4) @(negedge clk);
    ext_edge();
    wr(1, 1, 16'd3);
    ext_edge();
    chk("R10 old duty at tick 2", int'(pwm[1]), 0);
    ext_edge();
    chk("R10 old duty at tick 3", int'(pwm[1]), 0);
    ext_edge();
    ext_edge();
    ext_edge();
    chk("R10 new duty at tick 2 of next period", int'(pwm[1]), 1);

    // R7: peripheral tick source on channel 2, period 4, duty 1
    wr(2, 0, ctlw(1, 0, 1, 0, 3)); wr(2, 1, 16'd1);
    wr(0, 3, 16'h0004);
    repeat (4) @(negedge clk);
    chk("R7 peripheral start level", int'(pwm[2]), 1);
    for (int k = 1; k <= 6; k++) begin
      per_pulse();
      chk("R7 peripheral tick pattern", int'(pwm[2]), int'((k % 4) == 0));
    end

    // R1: PWM reset while running
    @(negedge clk) pwm_rst_n = 1'b0;
    #1;
    chk("R1 outputs cleared by PWM reset", int'(pwm), 0);
    repeat (3) @(negedge clk);
    pwm_rst_n = 1'b1;
    repeat (6) @(posedge clk);
    measure(0, 40, hi, rs);
    chk("R1 channel disabled after PWM reset", hi, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule